// File: doc/BRIEF.md
# Outbound Address Translation Window

This block maps local bus addresses onto link-side addresses through a small set of programmable outbound regions. Software first writes a viewport register to pick one region, then writes that region's base, limit, 64-bit target, transaction kind and enable through a fixed set of word offsets. Each request address is checked against every enabled region. The first matching region in index order replaces the address with its target plus the offset into the window, and it supplies the region's transaction kind. An address that matches no region leaves the block unchanged and is tagged as a memory access.

A separate helper turns a configuration request into the fields a configuration cycle needs. It takes a bus, device, function and register offset. It packs bus, device and function into a target word, selects the type-0 or type-1 configuration kind from the bus number, and word-aligns the offset. All results come from registers and appear one clock after the request.

Top module: `atu_outbound_xlate`

## Requirements
- R1: After synchronous reset every region is disabled and its registers read as zero. `out_valid`, `cfg_out_valid` and `rd_data` are low, and the first request after reset is a miss.
- R2: Register word offsets are: viewport 0x00, kind 0x04, control 0x08, base-low 0x0C, base-high 0x10, limit 0x14, target-low 0x18, target-high 0x1C. Region registers act on the region the viewport selects. The kind occupies bits 4:0 and reads back with the upper bits zero. Control bit 31 is enable and bit 30 is BAR-match mode. `rd_data` is valid the cycle after `rd_en`.
- R3: The viewport holds a direction in bit 31 (1 = inbound) and a region index in bits 3:0. When inbound is selected, or the index is not below NUM_REGIONS, writes to region registers are dropped and reads of them return 0.
- R4: A region hits when it is enabled, its base-high is zero, and base-low ≤ address ≤ limit, both bounds inclusive.
- R5: On a hit, one cycle after `req_valid`, `out_addr` = {target-high, target-low} + (address − base-low), `out_type` = the region's kind, `out_hit` = 1 and `out_region` = the region index.
- R6: On a miss, `out_addr` is the address zero-extended to 64 bits, `out_type` = 0 (memory) and `out_hit` = 0.
- R7: When several regions hit, the lowest index wins.
- R8: The BAR-match bit is stored and read back, but it does not change outbound matching or translation.
- R9: `cfg_target` holds bus in bits 31:24, device in bits 23:19 and function in bits 18:16, with bits 15:0 zero, one cycle after `cfg_valid`.
- R10: `cfg_type` is 4 (type-0) for bus numbers 0 and 1, and 5 (type-1) for bus numbers 2 and above.
- R11: `cfg_offset_out` is `cfg_offset` with its two low bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte offset for write |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Register byte offset for read |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| req_valid | input | 1 | Address request valid |
| req_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Translation result valid |
| out_hit | output | 1 | A region matched |
| out_region | output | IDX_W | Index of the matching region |
| out_type | output | 5 | Transaction kind |
| out_addr | output | 64 | Translated or passed-through address |
| cfg_valid | input | 1 | Configuration helper request |
| cfg_bus | input | 8 | Bus number |
| cfg_dev | input | 5 | Device number |
| cfg_func | input | 3 | Function number |
| cfg_offset | input | 12 | Configuration register offset |
| cfg_out_valid | output | 1 | Helper result valid |
| cfg_target | output | 32 | Packed bus/device/function word |
| cfg_type | output | 5 | Type-0 (4) or type-1 (5) kind |
| cfg_offset_out | output | 12 | Word-aligned offset |

## Verification
Requests are placed on the inclusive lower and upper edges of a window and one address outside each edge. This separates a correct inclusive compare from an off-by-one or strict compare. A stretch covered by two overlapping regions tells lowest-index priority apart from a last-match or OR'ed result. Disabling the winning region, and putting a non-zero base-high on the other, shows that the enable and the high-word checks each gate a hit. Register writes made with an inbound or out-of-range viewport are then read back through a valid viewport to show they landed nowhere. The configuration helper is driven with bus numbers 0, 1, 2 and 255 and unaligned offsets, which exposes a wrong kind threshold, a wrong field position or missed alignment.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int REG_AW    = 5;
  localparam int REG_W     = 32;
  localparam int KIND_W    = 5;
  localparam int VP_IDX_W  = 4;

  localparam logic [2:0] W_VIEW  = 3'd0;
  localparam logic [2:0] W_KIND  = 3'd1;
  localparam logic [2:0] W_CTRL  = 3'd2;
  localparam logic [2:0] W_BLO   = 3'd3;
  localparam logic [2:0] W_BHI   = 3'd4;
  localparam logic [2:0] W_LIM   = 3'd5;
  localparam logic [2:0] W_TLO   = 3'd6;
  localparam logic [2:0] W_THI   = 3'd7;

  localparam logic [KIND_W-1:0] KIND_MEM  = 5'd0;
  localparam logic [KIND_W-1:0] KIND_IO   = 5'd2;
  localparam logic [KIND_W-1:0] KIND_CFG0 = 5'd4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 5'd5;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic              en;
    logic              bar_mode;
    logic [REG_W-1:0]  base_lo;
    logic [REG_W-1:0]  base_hi;
    logic [REG_W-1:0]  limit;
    logic [REG_W-1:0]  tgt_lo;
    logic [REG_W-1:0]  tgt_hi;
  } window_t;
endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [REG_AW-1:0]              wr_addr,
  input  logic [REG_W-1:0]               wr_data,
  input  logic                           rd_en,
  input  logic [REG_AW-1:0]              rd_addr,
  output logic [REG_W-1:0]               rd_data,
  output window_t [NUM_REGIONS-1:0]      windows
);
  logic                vp_inbound;
  logic [VP_IDX_W-1:0] vp_idx;
  logic                vp_ok;

  assign vp_ok = !vp_inbound && (int'(vp_idx) < NUM_REGIONS);

  logic [2:0] wr_word, rd_word;
  assign wr_word = wr_addr[REG_AW-1:2];
  assign rd_word = rd_addr[REG_AW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      vp_inbound <= 1'b0;
      vp_idx     <= '0;
    end else if (wr_en && wr_word == W_VIEW) begin
      vp_inbound <= wr_data[31];
      vp_idx     <= wr_data[VP_IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_win
    logic hit_sel;
    assign hit_sel = wr_en && vp_ok && (vp_idx == VP_IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        windows[g] <= '0;
      end else if (hit_sel) begin
        case (wr_word)
          W_KIND: windows[g].kind    <= wr_data[KIND_W-1:0];
          W_CTRL: begin
            windows[g].en       <= wr_data[31];
            windows[g].bar_mode <= wr_data[30];
          end
          W_BLO:  windows[g].base_lo <= wr_data;
          W_BHI:  windows[g].base_hi <= wr_data;
          W_LIM:  windows[g].limit   <= wr_data;
          W_TLO:  windows[g].tgt_lo  <= wr_data;
          W_THI:  windows[g].tgt_hi  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  window_t          cur;
  logic [REG_W-1:0] rd_val;

  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (vp_ok && vp_idx == VP_IDX_W'(i)) cur = windows[i];
  end

  always_comb begin
    rd_val = '0;
    case (rd_word)
      W_VIEW:  rd_val = {vp_inbound, {(REG_W-1-VP_IDX_W){1'b0}}, vp_idx};
      W_KIND:  rd_val = {{(REG_W-KIND_W){1'b0}}, cur.kind};
      W_CTRL:  rd_val = {cur.en, cur.bar_mode, {(REG_W-2){1'b0}}};
      W_BLO:   rd_val = cur.base_lo;
      W_BHI:   rd_val = cur.base_hi;
      W_LIM:   rd_val = cur.limit;
      W_TLO:   rd_val = cur.tgt_lo;
      W_THI:   rd_val = cur.tgt_hi;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_val;
  end
endmodule

// File: rtl/atu_match.sv
module atu_match
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  window_t [NUM_REGIONS-1:0] windows,
  input  logic [REG_W-1:0]          addr,
  output logic [NUM_REGIONS-1:0]    hit_vec,
  output logic                      any_hit,
  output logic [IDX_W-1:0]          sel_idx,
  output logic [KIND_W-1:0]         sel_kind,
  output logic [2*REG_W-1:0]        sel_addr
);
  logic [2*REG_W-1:0] xlat [NUM_REGIONS];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
    logic [REG_W-1:0] delta;
    assign delta   = addr - windows[g].base_lo;
    assign hit_vec[g] = windows[g].en && (windows[g].base_hi == '0) &&
                        (addr >= windows[g].base_lo) && (addr <= windows[g].limit);
    assign xlat[g] = {windows[g].tgt_hi, windows[g].tgt_lo} + {{REG_W{1'b0}}, delta};
  end

  always_comb begin
    any_hit  = 1'b0;
    sel_idx  = '0;
    sel_kind = KIND_MEM;
    sel_addr = {{REG_W{1'b0}}, addr};
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit  = 1'b1;
        sel_idx  = IDX_W'(i);
        sel_kind = windows[i].kind;
        sel_addr = xlat[i];
      end
    end
  end
endmodule

// File: rtl/atu_cfg_pack.sv
module atu_cfg_pack
  import atu_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        bus,
  input  logic [4:0]        dev,
  input  logic [2:0]        func,
  input  logic [OFS_W-1:0]  offset,
  output logic              out_valid,
  output logic [REG_W-1:0]  target,
  output logic [KIND_W-1:0] kind,
  output logic [OFS_W-1:0]  offset_al
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      target    <= '0;
      kind      <= '0;
      offset_al <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        target    <= {bus, dev, func, 16'h0000};
        kind      <= (bus < 8'd2) ? KIND_CFG0 : KIND_CFG1;
        offset_al <= {offset[OFS_W-1:2], 2'b00};
      end
    end
  end
endmodule

// File: rtl/atu_outbound_xlate.sv
module atu_outbound_xlate
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int CFG_OFS_W   = 12,
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [REG_AW-1:0]     wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  rd_en,
  input  logic [REG_AW-1:0]     rd_addr,
  output logic [REG_W-1:0]      rd_data,
  input  logic                  req_valid,
  input  logic [REG_W-1:0]      req_addr,
  output logic                  out_valid,
  output logic                  out_hit,
  output logic [IDX_W-1:0]      out_region,
  output logic [KIND_W-1:0]     out_type,
  output logic [2*REG_W-1:0]    out_addr,
  input  logic                  cfg_valid,
  input  logic [7:0]            cfg_bus,
  input  logic [4:0]            cfg_dev,
  input  logic [2:0]            cfg_func,
  input  logic [CFG_OFS_W-1:0]  cfg_offset,
  output logic                  cfg_out_valid,
  output logic [REG_W-1:0]      cfg_target,
  output logic [KIND_W-1:0]     cfg_type,
  output logic [CFG_OFS_W-1:0]  cfg_offset_out
);
  window_t [NUM_REGIONS-1:0] windows;
  logic [NUM_REGIONS-1:0]    hit_vec;
  logic                      any_hit;
  logic [IDX_W-1:0]          sel_idx;
  logic [KIND_W-1:0]         sel_kind;
  logic [2*REG_W-1:0]        sel_addr;

  atu_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .windows(windows)
  );

  atu_match #(.NUM_REGIONS(NUM_REGIONS)) u_match (
    .windows(windows), .addr(req_addr),
    .hit_vec(hit_vec), .any_hit(any_hit), .sel_idx(sel_idx),
    .sel_kind(sel_kind), .sel_addr(sel_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_hit    <= 1'b0;
      out_region <= '0;
      out_type   <= '0;
      out_addr   <= '0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_hit    <= any_hit;
        out_region <= sel_idx;
        out_type   <= sel_kind;
        out_addr   <= sel_addr;
      end
    end
  end

  atu_cfg_pack #(.OFS_W(CFG_OFS_W)) u_cfg (
    .clk(clk), .rst(rst), .in_valid(cfg_valid),
    .bus(cfg_bus), .dev(cfg_dev), .func(cfg_func), .offset(cfg_offset),
    .out_valid(cfg_out_valid), .target(cfg_target), .kind(cfg_type),
    .offset_al(cfg_offset_out)
  );
endmodule

// File: rtl/atu_outbound_xlate_chk.sv
module atu_outbound_xlate_chk #(
  parameter int NUM_REGIONS = 2,
  parameter int CFG_OFS_W   = 12,
  parameter int IDX_W       = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [31:0]          req_addr,
  input logic                 out_valid,
  input logic                 out_hit,
  input logic [IDX_W-1:0]     out_region,
  input logic [4:0]           out_type,
  input logic [63:0]          out_addr,
  input logic [NUM_REGIONS-1:0] hit_vec,
  input logic                 cfg_out_valid,
  input logic [31:0]          cfg_target,
  input logic [4:0]           cfg_type,
  input logic [CFG_OFS_W-1:0] cfg_offset,
  input logic [CFG_OFS_W-1:0] cfg_offset_out
);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);

  a_r6_miss_passthrough: assert property (@(posedge clk) disable iff (rst)
    req_valid && !(|hit_vec) |=>
      !out_hit && out_type == 5'd0 && out_addr == {32'h0, $past(req_addr)});

  a_r7_low_index_wins: assert property (@(posedge clk) disable iff (rst)
    req_valid && hit_vec[0] |=> out_hit && out_region == '0);

  a_r9_low_half_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_out_valid |-> cfg_target[15:0] == 16'h0);

  a_r10_kind_by_bus: assert property (@(posedge clk) disable iff (rst)
    cfg_out_valid |-> cfg_type == ((cfg_target[31:24] < 8'd2) ? 5'd4 : 5'd5));

  a_r11_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_out_valid) |->
      cfg_offset_out[1:0] == 2'b00 &&
      cfg_offset_out[CFG_OFS_W-1:2] == $past(cfg_offset[CFG_OFS_W-1:2]));
endmodule

bind atu_outbound_xlate atu_outbound_xlate_chk #(
  .NUM_REGIONS(NUM_REGIONS), .CFG_OFS_W(CFG_OFS_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .out_valid(out_valid), .out_hit(out_hit), .out_region(out_region),
  .out_type(out_type), .out_addr(out_addr), .hit_vec(hit_vec),
  .cfg_out_valid(cfg_out_valid), .cfg_target(cfg_target), .cfg_type(cfg_type),
  .cfg_offset(cfg_offset), .cfg_offset_out(cfg_offset_out)
);

// File: tb/atu_outbound_xlate_tb.sv
module atu_outbound_xlate_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        wr_en = 0, rd_en = 0, req_valid = 0, cfg_valid = 0;
  logic [4:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, req_addr = 0;
  logic [31:0] rd_data;
  logic        out_valid, out_hit;
  logic [0:0]  out_region;
  logic [4:0]  out_type;
  logic [63:0] out_addr;
  logic [7:0]  cfg_bus = 0;
  logic [4:0]  cfg_dev = 0;
  logic [2:0]  cfg_func = 0;
  logic [11:0] cfg_offset = 0;
  logic        cfg_out_valid;
  logic [31:0] cfg_target;
  logic [4:0]  cfg_type;
  logic [11:0] cfg_offset_out;

  atu_outbound_xlate u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid),
    .out_hit(out_hit), .out_region(out_region), .out_type(out_type),
    .out_addr(out_addr), .cfg_valid(cfg_valid), .cfg_bus(cfg_bus),
    .cfg_dev(cfg_dev), .cfg_func(cfg_func), .cfg_offset(cfg_offset),
    .cfg_out_valid(cfg_out_valid), .cfg_target(cfg_target),
    .cfg_type(cfg_type), .cfg_offset_out(cfg_offset_out)
  );

  int tests = 0, fails = 0;

  typedef struct packed { logic hit; logic rgn; logic [4:0] kind; logic [63:0] addr; } xexp_t;
  typedef struct packed { logic [31:0] tgt; logic [4:0] kind; logic [11:0] ofs; } cexp_t;
  xexp_t xq[$];
  cexp_t cq[$];
  string xtag[$];
  string ctag[$];

  // independent model of the programmed windows
  logic        m_en [2];
  logic [31:0] m_blo[2], m_bhi[2], m_lim[2];
  logic [63:0] m_tgt[2];
  logic [4:0]  m_kind[2];

  function automatic xexp_t model(input logic [31:0] a);
    xexp_t e;
    e = '{hit: 1'b0, rgn: 1'b0, kind: 5'd0, addr: {32'h0, a}};
    for (int i = 1; i >= 0; i--)
      if (m_en[i] && m_bhi[i] == 0 && a >= m_blo[i] && a <= m_lim[i])
        e = '{hit: 1'b1, rgn: i[0], kind: m_kind[i], addr: m_tgt[i] + 64'(a - m_blo[i])};
    return e;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rreg(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
    check(tag, {32'h0, rd_data}, {32'h0, exp});
  endtask

  task automatic prog(input int i, input logic [4:0] k, input logic [31:0] blo,
                      input logic [31:0] lim, input logic [63:0] tgt);
    wreg(5'h00, 32'(i));
    wreg(5'h04, {27'h0, k});
    wreg(5'h0C, blo);
    wreg(5'h10, 32'h0);
    wreg(5'h14, lim);
    wreg(5'h18, tgt[31:0]);
    wreg(5'h1C, tgt[63:32]);
    wreg(5'h08, 32'h8000_0000);
    m_kind[i] = k; m_blo[i] = blo; m_bhi[i] = 0; m_lim[i] = lim; m_tgt[i] = tgt; m_en[i] = 1;
  endtask

  task automatic xreq(input string tag, input logic [31:0] a);
    @(negedge clk); req_valid = 1; req_addr = a;
    xq.push_back(model(a)); xtag.push_back(tag);
    @(negedge clk); req_valid = 0;
  endtask

  task automatic creq(input string tag, input logic [7:0] b, input logic [4:0] d,
                      input logic [2:0] f, input logic [11:0] o);
    cexp_t e;
    e.tgt  = {b, d, f, 16'h0};
    e.kind = (b < 2) ? 5'd4 : 5'd5;
    e.ofs  = o & 12'hFFC;
    @(negedge clk); cfg_valid = 1; cfg_bus = b; cfg_dev = d; cfg_func = f; cfg_offset = o;
    cq.push_back(e); ctag.push_back(tag);
    @(negedge clk); cfg_valid = 0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (xq.size() == 0) check("R5 unexpected result", 64'd1, 64'd0);
      else begin
        xexp_t e; string t;
        e = xq.pop_front(); t = xtag.pop_front();
        check({t, " hit"},  {63'h0, out_hit},    {63'h0, e.hit});
        check({t, " addr"}, out_addr,            e.addr);
        check({t, " kind"}, {59'h0, out_type},   {59'h0, e.kind});
        if (e.hit) check({t, " region"}, {63'h0, out_region}, {63'h0, e.rgn});
      end
    end
    if (!rst && cfg_out_valid) begin
      if (cq.size() == 0) check("R9 unexpected cfg result", 64'd1, 64'd0);
      else begin
        cexp_t e; string t;
        e = cq.pop_front(); t = ctag.pop_front();
        check({t, " R9 target"},  {32'h0, cfg_target},     {32'h0, e.tgt});
        check({t, " R10 kind"},   {59'h0, cfg_type},       {59'h0, e.kind});
        check({t, " R11 offset"}, {52'h0, cfg_offset_out}, {52'h0, e.ofs});
      end
    end
  end

  initial begin
    for (int i = 0; i < 2000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_en[i] = 0; m_blo[i] = 0; m_bhi[i] = 0; m_lim[i] = 0; m_tgt[i] = 0; m_kind[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", {63'h0, out_valid}, 64'h0);
    check("R1 cfg_out_valid", {63'h0, cfg_out_valid}, 64'h0);
    check("R1 rd_data", {32'h0, rd_data}, 64'h0);
    rreg("R1 ctrl region0", 5'h08, 32'h0);
    xreq("R1 miss after reset", 32'h1000_0000);

    prog(0, 5'd0, 32'h1000_0000, 32'h100F_FFFF, 64'h0000_0002_0000_0000);
    prog(1, 5'd5, 32'h1008_0000, 32'h1010_FFFF, 64'h0000_0000_4000_0000);

    // R2 readback of region 0
    wreg(5'h00, 32'h0);
    rreg("R2 viewport", 5'h00, 32'h0);
    rreg("R2 kind", 5'h04, 32'h0);
    rreg("R2 ctrl", 5'h08, 32'h8000_0000);
    rreg("R2 base-low", 5'h0C, 32'h1000_0000);
    rreg("R2 limit", 5'h14, 32'h100F_FFFF);
    rreg("R2 target-high", 5'h1C, 32'h2);
    wreg(5'h00, 32'h1);
    wreg(5'h04, 32'hFFFF_FFE5);
    rreg("R2 kind upper bits zero", 5'h04, 32'h5);

    // R4/R5/R6/R7 translation
    xreq("R4 lower edge", 32'h1000_0000);
    xreq("R4 upper edge", 32'h100F_FFFF);
    xreq("R4 below base", 32'h0FFF_FFFF);
    xreq("R7 overlap", 32'h1009_1234);
    xreq("R5 region1 type-1", 32'h1010_0000);
    xreq("R6 above all", 32'h1011_0000);

    // R3 inbound / out-of-range viewport
    wreg(5'h00, 32'h8000_0000);
    wreg(5'h0C, 32'hDEAD_BEEF);
    rreg("R3 inbound read zero", 5'h0C, 32'h0);
    wreg(5'h00, 32'h0000_0003);
    wreg(5'h0C, 32'hCAFE_0000);
    rreg("R3 bad index read zero", 5'h0C, 32'h0);
    wreg(5'h00, 32'h0);
    rreg("R3 region0 base untouched", 5'h0C, 32'h1000_0000);
    wreg(5'h00, 32'h1);
    rreg("R3 region1 base untouched", 5'h0C, 32'h1008_0000);

    // R8 BAR-match bit
    wreg(5'h08, 32'hC000_0000);
    rreg("R8 ctrl readback", 5'h08, 32'hC000_0000);
    xreq("R8 still hits region1", 32'h1010_8000);

    // R4 enable gate: disable region 0, overlap goes to region 1
    wreg(5'h00, 32'h0);
    wreg(5'h08, 32'h0);
    m_en[0] = 0;
    xreq("R4 disabled region0", 32'h1009_1234);
    // R4 base-high gate on region 1
    wreg(5'h00, 32'h1);
    wreg(5'h10, 32'h0000_0001);
    m_bhi[1] = 1;
    xreq("R4 base-high nonzero", 32'h1009_1234);

    // R9/R10/R11 configuration helper
    creq("bus0", 8'd0, 5'd1, 3'd0, 12'h013);
    creq("bus1", 8'd1, 5'd0, 3'd2, 12'h0FE);
    creq("bus2", 8'd2, 5'd31, 3'd7, 12'h101);
    creq("bus255", 8'd255, 5'd10, 3'd3, 12'hFFF);

    repeat (4) @(negedge clk);
    check("R5 all results seen", 64'(xq.size()), 64'd0);
    check("R9 all cfg results seen", 64'(cq.size()), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule